// File: doc/BRIEF.md
# Kickable Watchdog Interrupt Timer

This block is a software-liveness watchdog for a small control processor. A binary counter advances once for every pulse of a slow, free-running tick (nominally 19.2 kHz, supplied as a one-cycle enable in the system clock domain). Firmware proves it is alive by pulsing a kick strobe, which clears the counter. If the kicks stop, the counter's top stage rises after 8192 ticks (about 427 ms). That level is inverted to form an active-low nonmaskable interrupt request. A companion active-high protect output goes high together with the request, so that downstream circuitry opens its input relays and clears its state.

Left unattended, the block does not latch. The top counter stage keeps running as a square wave with equal low and high halves of 8192 ticks each. The interrupt therefore asserts and releases repeatedly until firmware kicks again. Holding the disable level high pins the counter at zero, which switches the watchdog off entirely.

Top module: `nmi_watchdog`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the counter is zero, `nmi_n` is 1 and `guard` is 0.
- R2: The counter advances by exactly one at each rising clock edge where `tick_en` is 1 and no clear is requested, and holds otherwise. Ticks spaced several cycles apart therefore reach the trip point after the same number of ticks as back-to-back ticks.
- R3: A `kick` pulse clears the counter to zero at the next edge. When `kick` and `tick_en` are both 1 in the same cycle, the clear wins and the counter is zero afterwards.
- R4: While `hold_clr` is 1 the counter stays at zero, so `nmi_n` stays 1 whatever `tick_en` does.
- R5: Counting from zero with no clear, `nmi_n` is still 1 after 8191 ticks (2^(CNT_W-1)-1) and becomes 0 at the edge that takes the 8192nd tick.
- R6: With no clear, the counter wraps after 16384 ticks (2^CNT_W) and `nmi_n` returns to 1. The output is a repeating square wave of 8192 ticks low and 8192 ticks high.
- R7: `guard` is always the logical inverse of `nmi_n`.
- R8: A `kick` while `nmi_n` is 0 returns `nmi_n` to 1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per period of the slow tick |
| kick | input | 1 | Firmware keep-alive strobe; clears the counter |
| hold_clr | input | 1 | Disable level; while high the counter is held at zero |
| nmi_n | output | 1 | Active-low nonmaskable interrupt request (inverted top counter stage) |
| guard | output | 1 | Active-high protect request; high whenever `nmi_n` is low |

## Verification
The counter's state reaches the ports only through its top bit. A corrupted low-order bit, a lost increment or a clear that loses to the tick therefore shows up only as a shift in the edge where `nmi_n` falls or rises. That shift can appear thousands of ticks after the fault. For this reason the bench compares both outputs against an independent tick-count model on every cycle, across full 8192-tick halves, with ticks both dense and sparse. A wrong tap or a broken inversion is visible as soon as the counter crosses its midpoint. A failed clear is visible at the first trip point after the kick that should have reset the count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WDT_CNT_W_DEFAULT = 14;

    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_KICK = 2'd1,
        CLR_HOLD = 2'd2
    } clr_src_e;

    typedef struct packed {
        logic     clear;
        logic     advance;
        clr_src_e src;
    } cnt_cmd_t;

    typedef struct packed {
        logic nmi_n;
        logic guard;
    } irq_out_t;

    function automatic cnt_cmd_t decode_cmd(input logic tick, input logic kick,
                                            input logic hold);
        cnt_cmd_t c;
        c.clear   = kick | hold;
        c.advance = tick & ~(kick | hold);
        if (hold)      c.src = CLR_HOLD;
        else if (kick) c.src = CLR_KICK;
        else           c.src = CLR_NONE;
        return c;
    endfunction

    function automatic irq_out_t stage_to_irq(input logic stage);
        irq_out_t o;
        o.nmi_n = ~stage;
        o.guard = stage;
        return o;
    endfunction

endpackage

// File: rtl/wdt_clear_ctrl.sv
module wdt_clear_ctrl
    import wdt_pkg::*;
(
    input  logic     tick_en,
    input  logic     kick,
    input  logic     hold_clr,
    output cnt_cmd_t cmd
);

    always_comb begin
        cmd = decode_cmd(tick_en, kick, hold_clr);
    end

endmodule

// File: rtl/wdt_ripple_cnt.sv
module wdt_ripple_cnt
    import wdt_pkg::*;
#(
    parameter int CNT_W = WDT_CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W:0] carry;

    assign carry[0] = cmd.advance;

    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        logic q;
        always_ff @(posedge clk) begin
            if (rst || cmd.clear) q <= 1'b0;
            else if (carry[i])    q <= ~q;
        end
        assign carry[i+1] = carry[i] & q;
        assign cnt[i]     = q;
    end

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (cnt == '0)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        cmd.advance |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clear && !cmd.advance) |=> $stable(cnt)); // R2

endmodule

// File: rtl/wdt_irq_stage.sv
module wdt_irq_stage
    import wdt_pkg::*;
(
    input  logic     tap,
    output irq_out_t irq
);

    always_comb begin
        irq = stage_to_irq(tap);
    end

endmodule

// File: rtl/nmi_watchdog.sv
module nmi_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W = WDT_CNT_W_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic kick,
    input  logic hold_clr,
    output logic nmi_n,
    output logic guard
);

    localparam int TAP = CNT_W - 1;

    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] cnt;
    irq_out_t         irq;

    wdt_clear_ctrl u_clr (
        .tick_en  (tick_en),
        .kick     (kick),
        .hold_clr (hold_clr),
        .cmd      (cmd)
    );

    wdt_ripple_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .cnt (cnt)
    );

    wdt_irq_stage u_irq (
        .tap (cnt[TAP]),
        .irq (irq)
    );

    assign nmi_n = irq.nmi_n;
    assign guard = irq.guard;

    AST_HOLD_KEEPS_QUIET: assert property (@(posedge clk) disable iff (rst)
        hold_clr |=> nmi_n); // R4

    AST_KICK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (kick && !nmi_n) |=> nmi_n); // R8

    AST_TRIP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_n) |-> ($past(tick_en) && !$past(kick) && !$past(hold_clr))); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (nmi_n && !guard)); // R1

endmodule

// File: tb/nmi_watchdog_bench.sv
module nmi_watchdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_TICKS = 8192;
    localparam int FULL_TICKS = 16384;
    localparam int WATCHDOG_CYCLES = 150000;

    typedef struct {
        bit    exp_nmi;
        bit    exp_grd;
        string req;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic kick = 1'b0;
    logic hold_clr = 1'b0;
    logic nmi_n;
    logic guard;

    sb_item_t sbq[$];
    int m_cnt = 0;
    int n_checks = 0;
    int n_fail = 0;
    int n_cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_watchdog u_nmi_watchdog (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .kick     (kick),
        .hold_clr (hold_clr),
        .nmi_n    (nmi_n),
        .guard    (guard)
    );

    // Driver: applies one cycle of stimulus, advances the model, pushes the expectation.
    task automatic cycle(input bit t, input bit k, input bit h, input bit r, input string req);
        sb_item_t it;
        @(negedge clk);
        tick_en  = t;
        kick     = k;
        hold_clr = h;
        rst      = r;
        @(posedge clk);
        if (r || k || h) m_cnt = 0;
        else if (t)      m_cnt = (m_cnt + 1) % FULL_TICKS;
        it.exp_nmi = (m_cnt < HALF_TICKS);
        it.exp_grd = (m_cnt >= HALF_TICKS);
        it.req     = req;
        sbq.push_back(it);
    endtask

    task automatic run_ticks(input int n, input int gap, input string req);
        for (int i = 0; i < n; i++) begin
            cycle(1'b1, 1'b0, 1'b0, 1'b0, req);
            for (int g = 0; g < gap; g++) cycle(1'b0, 1'b0, 1'b0, 1'b0, req);
        end
    endtask

    // Monitor: compares outputs away from the active edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_checks++;
            if (nmi_n !== it.exp_nmi) begin
                n_fail++;
                $display("FAIL %s nmi_n actual=%b expected=%b", it.req, nmi_n, it.exp_nmi);
            end
            n_checks++;
            if (guard !== it.exp_grd) begin
                n_fail++;
                $display("FAIL %s/R7 guard actual=%b expected=%b", it.req, guard, it.exp_grd);
            end
        end
    end

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > WATCHDOG_CYCLES && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", n_cycles, WATCHDOG_CYCLES);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, ticks and kicks ignored under reset
        cycle(1'b1, 1'b0, 1'b0, 1'b1, "R1");
        cycle(1'b1, 1'b1, 1'b0, 1'b1, "R1");
        cycle(1'b0, 1'b0, 1'b0, 1'b1, "R1");
        cycle(1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // R2/R5: dense ticks up to just below the trip point, then the trip tick
        run_ticks(HALF_TICKS - 1, 0, "R2");
        run_ticks(1, 0, "R5");
        // R6: low half, wrap back to high
        run_ticks(HALF_TICKS, 0, "R6");
        run_ticks(16, 0, "R6");

        // R8: kick while asserted releases at next edge
        cycle(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        run_ticks(HALF_TICKS + 5, 0, "R8");
        cycle(1'b0, 1'b1, 1'b0, 1'b0, "R8");

        // R3: clear beats a simultaneous tick
        run_ticks(HALF_TICKS - 1, 0, "R3");
        cycle(1'b1, 1'b1, 1'b0, 1'b0, "R3");
        run_ticks(1, 0, "R3");
        run_ticks(HALF_TICKS - 2, 0, "R3");
        run_ticks(2, 0, "R3");

        // R4: disable level holds counter at zero across many ticks
        for (int i = 0; i < 10000; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 10; i++)    cycle(1'b1, i[0], 1'b1, 1'b0, "R4");

        // R2: sparse ticks reach the trip after the same tick count
        run_ticks(HALF_TICKS - 1, 2, "R2");
        run_ticks(1, 2, "R5");
        run_ticks(40, 1, "R6");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule